// File: doc/BRIEF.md
# Masked Packed Single-Precision Square Root Unit

This unit takes a packed vector of 32-bit IEEE-754 single-precision values, 4, 8 or 16 lanes wide (128, 256 or 512 bits), and writes each lane's correctly rounded square root into a destination vector. The lane count, the masking, the broadcast of one scalar source, the choice of rounding control and the treatment of the destination bits above the active width all follow from an encoding class and its modifier inputs. The caller also supplies the old destination value, which is used for merged lanes and for preserved upper bits.

One iterative restoring square-root core is shared by all lanes. It produces one root bit per cycle: 24 significand bits plus a guard bit. A final sticky bit comes from the remainder. The unit visits only the active lanes, in ascending order. Lanes that are masked off cost no core cycles. Special operands (zeros, infinities, NaNs and negatives) finish in the lane-selection cycle. A one-cycle `done` pulse follows the last lane. Exception flags accumulate until reset.

Top module: `vsqrt_lanes`

## Requirements
- R1: The encoding class is `enc_cls` (00 legacy, 01 three-operand, 10 or 11 masked). The legacy class always works on 4 lanes. The other classes take their lane count from `vlen`: 00 gives 4 lanes, 01 gives 8, and 10 or 11 gives 16. Lane j is `dst[32j+31:32j]`.
- R2: Each active lane receives the square root of its operand, correctly rounded in the selected mode. The rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R3: `insn_rm` is used only when the class is masked, `vlen` selects 512 bits, `bcast` is 1 and `src_is_mem` is 0. In every other case `glob_rm` is used.
- R4: When the class is masked, `bcast` is 1 and `src_is_mem` is 1, every active lane uses `src[31:0]` as its operand.
- R5: In the masked class with `mask_en`=1, a lane whose `wmask` bit is 0 is inactive. With `zero_mask`=0 it receives the lane from `old_dst`; with `zero_mask`=1 it receives 0. Outside the masked class, or when `mask_en`=0, `wmask` has no effect.
- R6: For the three-operand and masked classes, every destination bit at or above the active width is 0.
- R7: For the legacy class, destination bits 511..128 equal `old_dst`.
- R8: When `rsv_field` is not 4'b1111, `ud_fault` is 1 during the `done` cycle and `dst` keeps its previous value.
- R9: `done` is a single-cycle pulse after the last active lane has been written. After reset, `dst`, `flags`, `done` and `ud_fault` are all 0.
- R10: `flags` bit 0 is invalid, bit 1 is denormal and bit 2 is inexact. Set bits stay set until reset.
- R11: The root of ±0 is the same zero and the root of +infinity is +infinity. A quiet NaN passes through unchanged. A signaling NaN, or any negative non-zero input, gives 32'hFFC00000 and sets the invalid flag.
- R12: A positive denormal operand is normalized, gives a correctly rounded normal result and sets the denormal flag.
- R13: The inexact flag is set exactly when a computed root has a non-zero guard bit or a non-zero remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| src | input | 512 | Packed source operand |
| src_is_mem | input | 1 | Source came from memory |
| bcast | input | 1 | Broadcast / rounding-override modifier |
| mask_en | input | 1 | Write mask in use |
| wmask | input | 16 | Per-lane write mask |
| zero_mask | input | 1 | 1: zero masked lanes, 0: merge |
| old_dst | input | 512 | Previous destination contents |
| insn_rm | input | 2 | Instruction rounding mode |
| glob_rm | input | 2 | Global rounding mode |
| enc_cls | input | 2 | Encoding class |
| vlen | input | 2 | Vector length code |
| rsv_field | input | 4 | Reserved register field |
| dst | output | 512 | Result vector |
| flags | output | 3 | Sticky {inexact, denormal, invalid} |
| ud_fault | output | 1 | Undefined-opcode fault, valid with done |
| done | output | 1 | Operation complete pulse |

## Verification
The assertions assume that `start` is raised only while the unit is idle and is held for exactly one cycle. They also assume that `old_dst` and the modifier inputs are sampled only on that cycle, so the mid-operation inputs do not matter. The bench pulses `start` for one cycle, then waits for `done` before it changes any input, which keeps the stimulus within these assumptions. The bench resets the unit before each scenario, so the sticky flags reflect that scenario alone. Test operands are chosen so that each root has a known bit pattern, either exact or exactly characterized: √2 rounds down to nearest and truncated, and up to the next code toward plus infinity.

// File: rtl/vsqrt_lanes.sv
module vsqrt_lanes #(
  parameter int MAX_LANES = 16,
  localparam int VW = 32 * MAX_LANES,
  localparam int LW = $clog2(MAX_LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] src,
  input  logic          src_is_mem,
  input  logic          bcast,
  input  logic          mask_en,
  input  logic [MAX_LANES-1:0] wmask,
  input  logic          zero_mask,
  input  logic [VW-1:0] old_dst,
  input  logic [1:0]    insn_rm,
  input  logic [1:0]    glob_rm,
  input  logic [1:0]    enc_cls,
  input  logic [1:0]    vlen,
  input  logic [3:0]    rsv_field,
  output logic [VW-1:0] dst,
  output logic [2:0]    flags,
  output logic          ud_fault,
  output logic          done
);
  typedef enum logic [1:0] {S_IDLE, S_PICK, S_CALC, S_DONE} st_t;
  st_t state;

  logic [VW-1:0]        src_q;
  logic [MAX_LANES-1:0] act_q;
  logic                 bc_q;
  logic [1:0]           rm_q, cls_q;
  logic [LW-1:0]        lane, nl_q;
  logic [49:0]          rad;
  logic [25:0]          rem;
  logic [24:0]          q;
  logic [4:0]           cnt;
  logic [7:0]           rexp;

  wire legacy = (enc_cls == 2'd0);
  wire masked = enc_cls[1];
  wire [LW-1:0] nl_in = (legacy || vlen == 2'd0) ? LW'(4) : (vlen == 2'd1) ? LW'(8) : LW'(16);
  wire [1:0] rm_in = (masked && vlen[1] && bcast && !src_is_mem) ? insn_rm : glob_rm;
  wire bc_in = masked && bcast && src_is_mem;

  logic [MAX_LANES-1:0] act_in;
  always_comb
    for (int j = 0; j < MAX_LANES; j++)
      act_in[j] = (j < int'(nl_in)) && (!masked || !mask_en || wmask[j]);

  logic          found;
  logic [LW-1:0] nidx;
  always_comb begin
    found = 1'b0;
    nidx  = '0;
    for (int j = MAX_LANES - 1; j >= 0; j--)
      if (act_q[j] && j >= int'(lane)) begin
        found = 1'b1;
        nidx  = LW'(j);
      end
  end

  wire [31:0] op = bc_q ? src_q[31:0] : src_q[nidx*32 +: 32];
  wire [7:0]  ex = op[30:23];
  wire [22:0] fr = op[22:0];
  wire is_zero = (ex == 8'd0) && (fr == 23'd0);
  wire is_den  = (ex == 8'd0) && (fr != 23'd0);
  wire is_nan  = (ex == 8'hFF) && (fr != 23'd0);
  wire special = is_zero || is_nan || (ex == 8'hFF) || op[31];
  wire spec_inv = !is_zero && ((is_nan && !fr[22]) || (!is_nan && op[31]));
  wire [31:0] spec_val = (is_zero || (is_nan && fr[22])) ? op :
                         (op[31] || is_nan) ? 32'hFFC00000 : op;

  logic [4:0] p;
  always_comb begin
    p = 5'd0;
    for (int i = 0; i < 23; i++)
      if (fr[i]) p = 5'(i);
  end

  wire [23:0] mant = is_den ? ({1'b0, fr} << (5'd23 - p)) : {1'b1, fr};
  wire signed [9:0] e_s = is_den ? $signed({5'b0, p}) - 10'sd149 : $signed({2'b0, ex}) - 10'sd127;
  wire signed [9:0] rexp_w = (e_s >>> 1) + 10'sd127;
  wire [49:0] rad_in = e_s[0] ? {mant, 26'b0} : {1'b0, mant, 25'b0};

  wire [27:0] rem_sh = {rem, rad[49:48]};
  wire [27:0] trial  = {1'b0, q, 2'b01};
  wire        ge     = rem_sh >= trial;
  wire [27:0] rem_nx = ge ? rem_sh - trial : rem_sh;
  wire [24:0] q_nx   = {q[23:0], ge};
  wire g  = q_nx[0];
  wire st = |rem_nx;
  wire inc = (rm_q == 2'b00) ? (g && (st || q_nx[1])) : (rm_q == 2'b10) ? (g || st) : 1'b0;
  wire [31:0] rres = {1'b0, rexp, q_nx[23:1]} + {31'b0, inc};

  assign done = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; dst <= '0; flags <= '0; ud_fault <= 1'b0;
      src_q <= '0; act_q <= '0; bc_q <= 1'b0; rm_q <= '0; cls_q <= '0; nl_q <= '0;
      lane <= '0; rad <= '0; rem <= '0; q <= '0; cnt <= '0; rexp <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          src_q <= src; act_q <= act_in; bc_q <= bc_in; rm_q <= rm_in;
          cls_q <= enc_cls; nl_q <= nl_in; lane <= '0;
          if (rsv_field != 4'b1111) begin
            ud_fault <= 1'b1;
            state    <= S_DONE;
          end else begin
            for (int j = 0; j < MAX_LANES; j++)
              if (j >= int'(nl_in))
                dst[j*32 +: 32] <= legacy ? old_dst[j*32 +: 32] : 32'd0;
              else
                dst[j*32 +: 32] <= (!act_in[j] && zero_mask) ? 32'd0 : old_dst[j*32 +: 32];
            state <= S_PICK;
          end
        end
        S_PICK: if (!found) state <= S_DONE;
          else if (special) begin
            dst[nidx*32 +: 32] <= spec_val;
            flags[0] <= flags[0] | spec_inv;
            lane <= nidx + LW'(1);
          end else begin
            lane <= nidx; rad <= rad_in; rem <= '0; q <= '0; cnt <= '0;
            rexp <= rexp_w[7:0];
            flags[1] <= flags[1] | is_den;
            state <= S_CALC;
          end
        S_CALC: begin
          rad <= rad << 2; rem <= rem_nx[25:0]; q <= q_nx; cnt <= cnt + 5'd1;
          if (cnt == 5'd24) begin
            dst[lane*32 +: 32] <= rres;
            flags[2] <= flags[2] | g | st;
            lane  <= lane + LW'(1);
            state <= S_PICK;
          end
        end
        default: begin
          ud_fault <= 1'b0;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_ud_hold: assert property (@(posedge clk) disable iff (!rst_n) ud_fault |-> (done && $stable(dst)));
  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n) ((flags & $past(flags)) == $past(flags)));
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ud_fault && cls_q != 2'd0 && nl_q == LW'(4)) |-> (dst[VW-1:128] == '0));
endmodule

// File: tb/tb_vsqrt_lanes.sv
`timescale 1ns/1ps
module tb_vsqrt_lanes;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [511:0] src = '0, old_dst = '0, dst;
  logic src_is_mem = 0, bcast = 0, mask_en = 0, zero_mask = 0;
  logic [15:0] wmask = '0;
  logic [1:0] insn_rm = 0, glob_rm = 0, enc_cls = 0, vlen = 0;
  logic [3:0] rsv_field = 4'hF;
  logic [2:0] flags;
  logic ud_fault, done;
  int n_chk = 0, n_fail = 0;

  vsqrt_lanes dut (.clk(clk), .rst_n(rst_n), .start(start), .src(src), .src_is_mem(src_is_mem),
    .bcast(bcast), .mask_en(mask_en), .wmask(wmask), .zero_mask(zero_mask), .old_dst(old_dst),
    .insn_rm(insn_rm), .glob_rm(glob_rm), .enc_cls(enc_cls), .vlen(vlen), .rsv_field(rsv_field),
    .dst(dst), .flags(flags), .ud_fault(ud_fault), .done(done));

  always #10 clk = ~clk;

  localparam logic [31:0] S2N = 32'h3FB504F3, S2U = 32'h3FB504F4, TWO = 32'h40000000;

  function automatic logic [31:0] pat(int j);
    case (j % 4) 0: return 32'h40800000; 1: return 32'h41100000; 2: return 32'h40100000; default: return 32'h3E800000; endcase
  endfunction
  function automatic logic [31:0] res(int j);
    case (j % 4) 0: return 32'h40000000; 1: return 32'h40400000; 2: return 32'h3FC00000; default: return 32'h3F000000; endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_vec(string tag, logic [511:0] exp);
    for (int j = 0; j < 16; j++) chk($sformatf("%s lane %0d", tag, j), dst[j*32 +: 32], exp[j*32 +: 32]);
  endtask

  task automatic defaults();
    src_is_mem = 0; bcast = 0; mask_en = 0; zero_mask = 0; wmask = '0;
    insn_rm = 0; glob_rm = 0; enc_cls = 0; vlen = 0; rsv_field = 4'hF;
    for (int j = 0; j < 16; j++) begin
      src[j*32 +: 32] = pat(j);
      old_dst[j*32 +: 32] = 32'hA0000000 + j;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; defaults();
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic go();
    int n = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual done=0 expected done=1");
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 reset dst", 32'(dst != '0), 32'd0);
    chk("R10 reset flags", 32'(flags), 32'd0);
    chk("R9 reset done/ud", {30'd0, done, ud_fault}, 32'd0);
  endtask

  task automatic t_legacy();
    logic [511:0] e;
    do_reset(); enc_cls = 0; vlen = 2'd2;
    e = old_dst;
    for (int j = 0; j < 4; j++) e[j*32 +: 32] = res(j);
    go();
    chk_vec("R1 R7 R2 legacy", e);
    chk("R13 exact no inexact", 32'(flags), 32'd0);
    chk("R9 ud low", 32'(ud_fault), 32'd0);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_vex256();
    logic [511:0] e = '0;
    do_reset(); enc_cls = 1; vlen = 2'd1; mask_en = 1; wmask = 16'h0000; zero_mask = 1;
    for (int j = 0; j < 8; j++) e[j*32 +: 32] = res(j);
    go();
    chk_vec("R1 R6 R5 three-operand 256, mask ignored", e);
  endtask

  task automatic t_mask(bit zm);
    logic [511:0] e;
    do_reset(); enc_cls = 2; vlen = 2'd2; mask_en = 1; wmask = 16'h5A0F; zero_mask = zm;
    for (int j = 0; j < 16; j++) e[j*32 +: 32] = wmask[j] ? res(j) : (zm ? 32'd0 : old_dst[j*32 +: 32]);
    go();
    chk_vec(zm ? "R5 zero masking" : "R5 merge masking", e);
  endtask

  task automatic t_nomask();
    logic [511:0] e;
    do_reset(); enc_cls = 2; vlen = 2'd2; mask_en = 0; wmask = 16'h0001; zero_mask = 1;
    for (int j = 0; j < 16; j++) e[j*32 +: 32] = res(j);
    go();
    chk_vec("R5 mask_en=0 all active", e);
  endtask

  task automatic t_bcast();
    logic [511:0] e = '0;
    do_reset(); enc_cls = 2; vlen = 2'd2; bcast = 1; src_is_mem = 1;
    src[31:0] = 32'h41100000;
    for (int j = 0; j < 16; j++) e[j*32 +: 32] = 32'h40400000;
    go();
    chk_vec("R4 broadcast 512", e);
    vlen = 2'd0; e = '0;
    for (int j = 0; j < 4; j++) e[j*32 +: 32] = 32'h40400000;
    go();
    chk_vec("R4 R6 broadcast 128 upper zero", e);
  endtask

  task automatic t_round();
    logic [511:0] e;
    do_reset(); enc_cls = 2; vlen = 2'd2; bcast = 1; src_is_mem = 0; insn_rm = 2'b10; glob_rm = 2'b00;
    for (int j = 0; j < 16; j++) src[j*32 +: 32] = TWO;
    for (int j = 0; j < 16; j++) e[j*32 +: 32] = S2U;
    go();
    chk_vec("R3 R2 override toward +inf", e);
    chk("R13 inexact set", 32'(flags), 32'd4);
    vlen = 2'd1; e = '0;
    for (int j = 0; j < 8; j++) e[j*32 +: 32] = S2N;
    go();
    chk_vec("R3 no override at 256", e);
    enc_cls = 1; vlen = 2'd0; glob_rm = 2'b01; insn_rm = 2'b10; e = '0;
    for (int j = 0; j < 4; j++) e[j*32 +: 32] = S2N;
    go();
    chk_vec("R3 R2 global toward -inf", e);
    glob_rm = 2'b10;
    for (int j = 0; j < 4; j++) e[j*32 +: 32] = S2U;
    go();
    chk_vec("R2 global toward +inf", e);
    glob_rm = 2'b11;
    for (int j = 0; j < 4; j++) e[j*32 +: 32] = S2N;
    go();
    chk_vec("R2 global toward zero", e);
  endtask

  task automatic t_special();
    logic [511:0] e;
    logic [31:0] si [7] = '{32'h00000000, 32'h80000000, 32'h7F800000, 32'hC0800000, 32'h7F800001, 32'h7FC12345, 32'hFF800000};
    logic [31:0] so [7] = '{32'h00000000, 32'h80000000, 32'h7F800000, 32'hFFC00000, 32'hFFC00000, 32'h7FC12345, 32'hFFC00000};
    do_reset(); enc_cls = 2; vlen = 2'd2;
    for (int j = 0; j < 16; j++) begin src[j*32 +: 32] = 32'h40800000; e[j*32 +: 32] = TWO; end
    for (int j = 0; j < 7; j++) begin src[j*32 +: 32] = si[j]; e[j*32 +: 32] = so[j]; end
    go();
    chk_vec("R11 special operands", e);
    chk("R11 R10 invalid only", 32'(flags), 32'd1);
    src[7*32 +: 32] = 32'h00000001; e[7*32 +: 32] = 32'h1A3504F3;
    src[8*32 +: 32] = 32'h00400000; e[8*32 +: 32] = 32'h1FB504F3;
    go();
    chk_vec("R12 denormal operands", e);
    chk("R10 R12 R13 flags", 32'(flags), 32'd7);
  endtask

  task automatic t_ud();
    logic [511:0] prev;
    do_reset(); enc_cls = 1; vlen = 2'd0;
    go();
    prev = dst;
    for (int j = 0; j < 16; j++) src[j*32 +: 32] = TWO;
    rsv_field = 4'b0111; enc_cls = 2; vlen = 2'd2;
    go();
    chk("R8 ud_fault", 32'(ud_fault), 32'd1);
    chk_vec("R8 dst unchanged", prev);
    chk("R8 no flags", 32'(flags), 32'd0);
    @(negedge clk);
    chk("R8 ud clears", {30'd0, done, ud_fault}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_legacy();
    t_vex256();
    t_mask(1'b0);
    t_mask(1'b1);
    t_nomask();
    t_bcast();
    t_round();
    t_special();
    t_ud();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule